// File: doc/BRIEF.md
# Multicycle 32-bit Processor Core

This block is a small 32-bit processor that spreads each instruction across several short clock cycles. A phase controller steps every instruction through fetch, operand read, execute, memory access and write-back, and each instruction uses only the phases it needs. Between the phases sit separately enabled holding registers: the instruction word, two operand latches, the ALU result and the loaded memory word. The program counter has its own enable as well. The core handles add and subtract between registers, OR with an immediate, word load, word store, branch on equality and an absolute jump.

One word-addressed array inside the block holds both instructions and data. It is written on the clock edge, and its read value is captured into the instruction or memory-data register on the next edge. While `run` is low the core is frozen, and a loader port may write words into the array. This is how a program and its data are placed before execution starts. Register-file writes and store writes are brought out as single-cycle strobes, so the effect of each instruction can be seen from outside.

Top module: `mc_core`

## Requirements
- R1: While `rst_n` is low, and for the two cycles of synchronised release after it, `pc_o` is 0, `phase_o` is 0 (fetch) and neither write strobe is asserted.
- R2: While `run` is low, `phase_o` and `pc_o` hold, neither strobe is asserted, and a loader write (`ld_we`, word index `ld_addr`, `ld_data`) lands in the array. Loader writes are accepted only while `run` is low.
- R3: Phase codes are fetch 0, operand 1, execute 2, load read 3, write-back 4, store 5, branch 6, jump 7. Every instruction starts in phase 0 and returns to it. A load takes 5 cycles; register ops, OR-immediate and store take 4; branch and jump take 3. At most one strobe is asserted, only in the final phase, and the load always goes from phase 3 to phase 4.
- R4: Opcode bits 31:26 = 000000 selects a register op. It reads rs (bits 25:21) and rt (bits 20:16) and writes rd (bits 15:11). Function bit 1 = 0 adds (e.g. 0x21) and function bit 1 = 1 subtracts rs minus rt (e.g. 0x23).
- R5: Opcode 001101 writes rt with rs OR the zero-extended 16-bit immediate in bits 15:0.
- R6: Opcode 100011 loads into rt the word at byte address rs + sign-extended immediate. Opcode 101011 stores rt there and strobes `dm_we_o` with that byte address and the data. The array index is address bits [AW+1:2].
- R7: Register 0 always reads as zero. A write aimed at it changes nothing and raises no `rf_we_o`.
- R8: Opcode 000100 compares rs and rt. If they are equal, the PC becomes PC+4 plus the sign-extended immediate shifted left by 2. Otherwise it becomes PC+4. The PC is always word aligned.
- R9: Opcode 000010 sets the PC to bits 31:28 of PC+4 joined with bits 25:0 of the instruction and two zero bits.
- R10: The PC changes only in the final phase of an instruction; every non-control instruction advances it by 4. An unknown opcode does nothing else and takes 2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| run | input | 1 | Core steps when high; frozen and loader enabled when low |
| ld_we | input | 1 | Loader write enable (honoured only while run is low) |
| ld_addr | input | MEM_AW | Loader word index |
| ld_data | input | 32 | Loader write data |
| pc_o | output | 32 | Current program counter |
| phase_o | output | 3 | Current controller phase |
| rf_we_o | output | 1 | Register-file write strobe (never for register 0) |
| rf_waddr_o | output | 5 | Register being written |
| rf_wdata_o | output | 32 | Value being written |
| dm_we_o | output | 1 | Store strobe |
| dm_addr_o | output | 32 | Store byte address |
| dm_wdata_o | output | 32 | Store data |

## Verification
If the controller takes a wrong transition, the cycle count between two phase-0 entries changes at once. A missing or extra strobe also appears within that same instruction. A corrupted operand, result or memory-data register shows up in the strobe value of the instruction that uses it, so one instruction later at most. A wrong general register may stay hidden until a later instruction reads it, so the stimulus reads back every register it writes. A PC error is caught at the next fetch. That is why the PC is compared at every instruction boundary.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
  localparam int XLEN   = 32;
  localparam int NREGS  = 32;
  localparam int REG_AW = $clog2(NREGS);

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_J     = 6'b000010;

  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_DECODE = 3'd1,
    PH_EXEC   = 3'd2,
    PH_MEMRD  = 3'd3,
    PH_WB     = 3'd4,
    PH_MEMWR  = 3'd5,
    PH_BRANCH = 3'd6,
    PH_JUMP   = 3'd7
  } phase_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR} aluop_e;
  typedef enum logic [1:0] {PC_SEQ, PC_BR, PC_JMP} pcsel_e;

  typedef struct packed {
    logic   ir_en;
    logic   ab_en;
    logic   s_en;
    logic   m_en;
    logic   pc_en;
    pcsel_e pc_sel;
    aluop_e alu_op;
    logic   alu_b_imm;
    logic   rf_we;
    logic   rf_dst_rd;
    logic   rf_from_m;
    logic   mem_we;
    logic   mem_use_s;
  } ctrl_t;
endpackage

// File: rtl/mc_regfile.sv
`timescale 1ns/1ps
module mc_regfile #(
  parameter  int DW   = 32,
  parameter  int NREG = 32,
  localparam int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [DW-1:0] rd1,
  output logic [DW-1:0] rd2,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata
);
  logic [DW-1:0] regs_q [NREG];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs_q[waddr] <= wdata;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
endmodule

// File: rtl/mc_alu.sv
`timescale 1ns/1ps
module mc_alu
  import mc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  aluop_e        op,
  output logic [DW-1:0] y,
  output logic          zero
);
  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/mc_mem.sv
`timescale 1ns/1ps
module mc_mem #(
  parameter  int DW    = 32,
  parameter  int WORDS = 256,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells_q [WORDS];

  always_ff @(posedge clk) begin
    if (we) cells_q[addr] <= wdata;
  end

  assign rdata = cells_q[addr];
endmodule

// File: rtl/mc_ctrl.sv
`timescale 1ns/1ps
module mc_ctrl
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [5:0] opcode,
  input  logic       sub_sel,
  input  logic       alu_zero,
  output phase_e     phase,
  output ctrl_t      ctl
);
  phase_e phase_nxt;

  always_comb begin
    ctl       = '0;
    phase_nxt = phase;
    if (run) begin
      case (phase)
        PH_FETCH: begin
          ctl.ir_en = 1'b1;
          phase_nxt = PH_DECODE;
        end
        PH_DECODE: begin
          ctl.ab_en = 1'b1;
          case (opcode)
            OP_RTYPE, OP_ORI, OP_LW, OP_SW: phase_nxt = PH_EXEC;
            OP_BEQ:  phase_nxt = PH_BRANCH;
            OP_J:    phase_nxt = PH_JUMP;
            default: begin
              ctl.pc_en  = 1'b1;
              ctl.pc_sel = PC_SEQ;
              phase_nxt  = PH_FETCH;
            end
          endcase
        end
        PH_EXEC: begin
          ctl.s_en      = 1'b1;
          ctl.alu_b_imm = (opcode != OP_RTYPE);
          if (opcode == OP_RTYPE)    ctl.alu_op = sub_sel ? ALU_SUB : ALU_ADD;
          else if (opcode == OP_ORI) ctl.alu_op = ALU_OR;
          else                       ctl.alu_op = ALU_ADD;
          if (opcode == OP_LW)       phase_nxt = PH_MEMRD;
          else if (opcode == OP_SW)  phase_nxt = PH_MEMWR;
          else                       phase_nxt = PH_WB;
        end
        PH_MEMRD: begin
          ctl.m_en      = 1'b1;
          ctl.mem_use_s = 1'b1;
          phase_nxt     = PH_WB;
        end
        PH_WB: begin
          ctl.rf_we     = 1'b1;
          ctl.rf_dst_rd = (opcode == OP_RTYPE);
          ctl.rf_from_m = (opcode == OP_LW);
          ctl.pc_en     = 1'b1;
          ctl.pc_sel    = PC_SEQ;
          phase_nxt     = PH_FETCH;
        end
        PH_MEMWR: begin
          ctl.mem_we    = 1'b1;
          ctl.mem_use_s = 1'b1;
          ctl.pc_en     = 1'b1;
          ctl.pc_sel    = PC_SEQ;
          phase_nxt     = PH_FETCH;
        end
        PH_BRANCH: begin
          ctl.alu_op = ALU_SUB;
          ctl.pc_en  = 1'b1;
          ctl.pc_sel = alu_zero ? PC_BR : PC_SEQ;
          phase_nxt  = PH_FETCH;
        end
        PH_JUMP: begin
          ctl.pc_en  = 1'b1;
          ctl.pc_sel = PC_JMP;
          phase_nxt  = PH_FETCH;
        end
        default: phase_nxt = PH_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_FETCH;
    else        phase <= phase_nxt;
  end
endmodule

// File: rtl/mc_core.sv
`timescale 1ns/1ps
module mc_core
  import mc_pkg::*;
#(
  parameter  int MEM_WORDS = 256,
  localparam int MEM_AW    = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ld_we,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [XLEN-1:0]   ld_data,
  output logic [XLEN-1:0]   pc_o,
  output logic [2:0]        phase_o,
  output logic              rf_we_o,
  output logic [REG_AW-1:0] rf_waddr_o,
  output logic [XLEN-1:0]   rf_wdata_o,
  output logic              dm_we_o,
  output logic [XLEN-1:0]   dm_addr_o,
  output logic [XLEN-1:0]   dm_wdata_o
);
  // reset: asserted asynchronously, released after two clean edges
  logic [1:0] rst_pipe_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  // stage registers
  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, s_q, m_q;
  logic [XLEN-1:0] pc_nxt, pc_plus4, br_tgt, jmp_tgt;
  logic [XLEN-1:0] rd1, rd2, alu_b, alu_y, imm_sext, imm_zext, imm_ext;
  logic [XLEN-1:0] mem_rdata, mem_wdata;
  logic [MEM_AW-1:0] mem_addr;
  logic              mem_we, alu_zero;
  logic [5:0]        opcode;
  logic [REG_AW-1:0] rs, rt, rd, rf_waddr;
  logic [XLEN-1:0]   rf_wdata;
  phase_e            phase;
  ctrl_t             ctl;

  assign opcode   = ir_q[31:26];
  assign rs       = ir_q[25:21];
  assign rt       = ir_q[20:16];
  assign rd       = ir_q[15:11];
  assign imm_sext = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
  assign imm_zext = {{(XLEN-16){1'b0}}, ir_q[15:0]};
  assign imm_ext  = (opcode == OP_ORI) ? imm_zext : imm_sext;

  mc_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .run      (run),
    .opcode   (opcode),
    .sub_sel  (ir_q[1]),
    .alu_zero (alu_zero),
    .phase    (phase),
    .ctl      (ctl)
  );

  mc_regfile #(.DW(XLEN), .NREG(NREGS)) u_rf (
    .clk   (clk),
    .ra1   (rs),
    .ra2   (rt),
    .rd1   (rd1),
    .rd2   (rd2),
    .we    (ctl.rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata)
  );

  assign alu_b = ctl.alu_b_imm ? imm_ext : b_q;

  mc_alu #(.DW(XLEN)) u_alu (
    .a    (a_q),
    .b    (alu_b),
    .op   (ctl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // shared instruction/data array; loader owns the write port while frozen
  assign mem_addr  = run ? (ctl.mem_use_s ? s_q[MEM_AW+1:2] : pc_q[MEM_AW+1:2]) : ld_addr;
  assign mem_we    = run ? ctl.mem_we : ld_we;
  assign mem_wdata = run ? b_q : ld_data;

  mc_mem #(.DW(XLEN), .WORDS(MEM_WORDS)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  // next PC selection
  assign pc_plus4 = pc_q + XLEN'(4);
  assign br_tgt   = pc_plus4 + {imm_sext[XLEN-3:0], 2'b00};
  assign jmp_tgt  = {pc_plus4[XLEN-1:XLEN-4], ir_q[25:0], 2'b00};

  always_comb begin
    case (ctl.pc_sel)
      PC_BR:   pc_nxt = br_tgt;
      PC_JMP:  pc_nxt = jmp_tgt;
      default: pc_nxt = pc_plus4;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pc_q <= '0;
      ir_q <= '0;
    end else begin
      if (ctl.pc_en) pc_q <= pc_nxt;
      if (ctl.ir_en) ir_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.ab_en) begin
      a_q <= rd1;
      b_q <= rd2;
    end
    if (ctl.s_en) s_q <= alu_y;
    if (ctl.m_en) m_q <= mem_rdata;
  end

  assign rf_waddr = ctl.rf_dst_rd ? rd : rt;
  assign rf_wdata = ctl.rf_from_m ? m_q : s_q;

  assign pc_o       = pc_q;
  assign phase_o    = phase;
  assign rf_we_o    = ctl.rf_we && (rf_waddr != '0);
  assign rf_waddr_o = rf_waddr;
  assign rf_wdata_o = rf_wdata;
  assign dm_we_o    = ctl.mem_we;
  assign dm_addr_o  = s_q;
  assign dm_wdata_o = b_q;
endmodule

// File: rtl/mc_core_chk.sv
`timescale 1ns/1ps
module mc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic [31:0] pc_o,
  input logic [2:0]  phase_o,
  input logic        rf_we_o,
  input logic [4:0]  rf_waddr_o,
  input logic        dm_we_o
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(pc_o) && $stable(phase_o)));

  p_hold_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!rf_we_o && !dm_we_o));

  p_fetch_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd0) |-> (!rf_we_o && !dm_we_o));

  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we_o, dm_we_o}));

  p_lw_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase_o == 3'd3) |=> (phase_o == 3'd4));

  p_pc_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (phase_o == 3'd0 || phase_o == 3'd2 || phase_o == 3'd3)) |=> $stable(pc_o));

  p_no_r0_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (rf_waddr_o != 5'd0));

  p_pc_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_o[1:0] == 2'b00);
endmodule

bind mc_core mc_core_chk u_mc_core_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .pc_o       (pc_o),
  .phase_o    (phase_o),
  .rf_we_o    (rf_we_o),
  .rf_waddr_o (rf_waddr_o),
  .dm_we_o    (dm_we_o)
);

// File: tb/test_mc_core.sv
`timescale 1ns/1ps
module test_mc_core;
  localparam int WORDS = 256;

  logic        clk = 1'b0;
  logic        rst_n, run, ld_we;
  logic [7:0]  ld_addr;
  logic [31:0] ld_data;
  logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic [2:0]  phase_o;
  logic        rf_we_o, dm_we_o;
  logic [4:0]  rf_waddr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] mmem [WORDS];
  logic [31:0] mreg [32];
  logic [31:0] mpc;

  always #4 clk = ~clk;

  mc_core #(.MEM_WORDS(WORDS)) i_mc_core (
    .clk(clk), .rst_n(rst_n), .run(run),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .pc_o(pc_o), .phase_o(phase_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  // reference step computed from the requirements
  task automatic model_step(output int cyc, output bit erf, output logic [4:0] era,
                            output logic [31:0] erd, output bit edm,
                            output logic [31:0] eda, output logic [31:0] edd,
                            output string tag);
    logic [31:0] ins, pc4, va, vb, sx;
    ins = mmem[mpc[9:2]];
    pc4 = mpc + 32'd4;
    sx  = {{16{ins[15]}}, ins[15:0]};
    va  = mreg[ins[25:21]];
    vb  = mreg[ins[20:16]];
    erf = 1'b0; edm = 1'b0; era = '0; erd = '0; eda = '0; edd = '0;
    mpc = pc4;
    case (ins[31:26])
      6'b000000: begin cyc = 4; tag = "R4"; era = ins[15:11]; erd = ins[1] ? va - vb : va + vb; end
      6'b001101: begin cyc = 4; tag = "R5"; era = ins[20:16]; erd = va | {16'h0, ins[15:0]}; end
      6'b100011: begin cyc = 5; tag = "R6"; era = ins[20:16]; eda = va + sx; erd = mmem[eda[9:2]]; end
      6'b101011: begin
        cyc = 4; tag = "R6"; edm = 1'b1; eda = va + sx; edd = vb; mmem[eda[9:2]] = vb;
      end
      6'b000100: begin cyc = 3; tag = "R8"; if (va == vb) mpc = pc4 + {sx[29:0], 2'b00}; end
      6'b000010: begin cyc = 3; tag = "R9"; mpc = {pc4[31:28], ins[25:0], 2'b00}; end
      default:   begin cyc = 2; tag = "R10"; end
    endcase
    if (ins[31:26] == 6'b000000 || ins[31:26] == 6'b001101 || ins[31:26] == 6'b100011) begin
      if (era == 5'd0) tag = "R7";
      else begin erf = 1'b1; mreg[era] = erd; end
    end
  endtask

  task automatic run_instr(input int freeze_at);
    int cyc, n;
    bit erf, edm, grf, gdm;
    logic [4:0] era, ga;
    logic [31:0] erd, eda, edd, gd, gda, gdd, ph, pv, val;
    string tag;
    chk("R3 start phase", {29'd0, phase_o}, 32'd0);
    model_step(cyc, erf, era, erd, edm, eda, edd, tag);
    n = 0; grf = 0; gdm = 0; ga = '0; gd = '0; gda = '0; gdd = '0;
    do begin
      if (rf_we_o) begin grf = 1'b1; ga = rf_waddr_o; gd = rf_wdata_o; end
      if (dm_we_o) begin gdm = 1'b1; gda = dm_addr_o; gdd = dm_wdata_o; end
      if (n == freeze_at) begin
        ph = {29'd0, phase_o}; pv = pc_o; val = $urandom;
        run = 1'b0; ld_we = 1'b1; ld_addr = 8'd255; ld_data = val;
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          ld_we = 1'b0;
          chk("R2 phase held", {29'd0, phase_o}, ph);
          chk("R2 pc held", pc_o, pv);
          chk("R2 no strobe", {30'd0, rf_we_o, dm_we_o}, 32'd0);
        end
        mmem[255] = val;
        run = 1'b1;
      end
      @(negedge clk);
      n++;
    end while (phase_o != 3'd0 && n < 12);
    chk("R3 cycles", n, cyc);
    chk({tag, " rf strobe"}, {31'd0, grf}, {31'd0, erf});
    if (erf) begin
      chk({tag, " rf addr"}, {27'd0, ga}, {27'd0, era});
      chk({tag, " rf data"}, gd, erd);
    end
    chk({tag, " store strobe"}, {31'd0, gdm}, {31'd0, edm});
    if (edm) begin
      chk({tag, " store addr"}, gda, eda);
      chk({tag, " store data"}, gdd, edd);
    end
    chk({tag, " next pc"}, pc_o, mpc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int sel, rs, rt, rd;
    void'($urandom(32'd1729));
    rst_n = 1'b0; run = 1'b0; ld_we = 1'b0; ld_addr = '0; ld_data = '0;
    for (int i = 0; i < 32; i++) mreg[i] = '0;
    mpc = '0;

    // program: init r1..r8, random body, directed tail
    for (int i = 0; i < WORDS; i++) mmem[i] = 32'hFC00_0000;
    for (int i = 0; i < 8; i++) mmem[i] = enc_i(6'b001101, 0, i + 1, 16'($urandom));
    for (int i = 8; i < 48; i++) begin
      sel = $urandom_range(0, 4);
      rs = $urandom_range(1, 8); rt = $urandom_range(1, 8); rd = $urandom_range(0, 8);
      case (sel)
        0: mmem[i] = enc_r(rs, rt, rd, 6'h21);
        1: mmem[i] = enc_r(rs, rt, rd, 6'h23);
        2: mmem[i] = enc_i(6'b001101, rs, rt, 16'($urandom));
        3: mmem[i] = enc_i(6'b100011, 0, rt, 16'(16'h0300 + 4 * $urandom_range(0, 15)));
        default: mmem[i] = enc_i(6'b101011, 0, rt, 16'(16'h0300 + 4 * $urandom_range(0, 15)));
      endcase
    end
    mmem[48] = enc_i(6'b001101, 0, 10, 16'h0400);
    mmem[49] = enc_i(6'b000100, 1, 1, 16'd2);          // R8 taken forward
    mmem[50] = enc_i(6'b001101, 0, 11, 16'hDEAD);
    mmem[51] = enc_i(6'b001101, 0, 11, 16'hBEEF);
    mmem[52] = enc_i(6'b001101, 0, 0, 16'h0055);       // R7 write to r0 ignored
    mmem[53] = enc_r(0, 1, 9, 6'h21);                  // R7 r0 reads zero
    mmem[54] = enc_i(6'b000100, 0, 10, 16'd5);         // R8 not taken
    mmem[55] = enc_i(6'b100011, 10, 12, 16'hFFFC);     // R6 negative offset
    mmem[56] = 32'hFC00_0000;                          // R10 unknown opcode
    mmem[57] = enc_r(12, 9, 13, 6'h23);
    mmem[58] = {6'b000010, 26'd60};                    // R9 jump
    mmem[59] = enc_i(6'b001101, 0, 11, 16'h1111);
    mmem[60] = enc_i(6'b000100, 0, 0, 16'hFFFF);       // R8 backward self loop
    for (int i = 192; i < WORDS; i++) mmem[i] = $urandom;

    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 pc in reset", pc_o, 32'd0);
    chk("R1 phase in reset", {29'd0, phase_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pc after release", pc_o, 32'd0);
    chk("R1 strobes after release", {30'd0, rf_we_o, dm_we_o}, 32'd0);
    @(negedge clk);

    // R2 loader writes while frozen
    for (int i = 0; i < WORDS; i++) begin
      ld_we = 1'b1; ld_addr = 8'(i); ld_data = mmem[i];
      @(negedge clk);
    end
    ld_we = 1'b0;
    chk("R2 pc idle while loading", pc_o, 32'd0);
    chk("R2 phase idle while loading", {29'd0, phase_o}, 32'd0);
    run = 1'b1;

    for (int i = 0; i < 62; i++)
      run_instr(i == 20 ? 2 : (i == 30 ? 0 : -1));

    // R1 asynchronous assertion mid-run
    rst_n = 1'b0;
    #1;
    chk("R1 pc async reset", pc_o, 32'd0);
    chk("R1 phase async reset", {29'd0, phase_o}, 32'd0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule